// File: doc/BRIEF.md
# Elapsed Time Counter with Alarm

This block measures how long an external condition has been active. A time-base tick advances a 32-bit working count while the event input, after a two-flop synchroniser, reads high. The count stops at all ones and never wraps. A persistent shadow copy of the count stands in for nonvolatile storage. Each time the synchronised event input falls, the working count is saved into the shadow copy. After reset, the working count is restored from the shadow.

A host writes through a simple register port. A write is first staged. It takes effect when the transaction-end strobe arrives. A count write sets both the working count and the shadow copy, so writing zero clears the elapsed time. A count write only lands if the synchronised event input is low at the strobe. A threshold write is always accepted. A registered flag is set while a nonzero threshold is at or below the working count, and it clears by itself once that stops being true. A zero threshold turns the flag off.

Top module: `elapsed_timer_top`

## Requirements
- R1: On reset the shadow copy takes the value of parameter PERSIST_INIT (default 0x40) and the threshold is zero. On the first clock after reset the working count is loaded from the shadow copy. The flag reads 0.
- R2: The working count rises by one on each clock with tick_i high while the synchronised event is high. With the event low, ticks leave the count unchanged.
- R3: The working count saturates at all ones. Further ticks hold it there.
- R4: The third rising clock after event_i falls copies the working count into the shadow copy. The count itself is not changed by this.
- R5: A count write staged with wr_en_i and wr_sel_i=0 is committed at xact_end_i. It sets both the working count and the shadow copy, but only if the synchronised event is low at the strobe. Otherwise it is dropped and both values are unchanged.
- R6: A threshold write (wr_sel_i=1) is committed at xact_end_i whatever the event level.
- R7: One clock after the working count becomes equal to or greater than a nonzero threshold, alarm_o and bit 0 of read address 3 go high.
- R8: While the threshold is zero, the flag stays low whatever the count.
- R9: The flag clears by itself one clock after the condition stops holding, for example when the count is rewritten to zero or the threshold is raised above the count.
- R10: If a count commit and an event falling edge fall in the same clock, the written value goes into both the working count and the shadow copy.
- R11: rd_data_o is combinational from rd_sel_i. Address 0 gives the count, 1 the shadow copy, 2 the threshold, and 3 the flag in bit 0 with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick, one clock wide |
| event_i | input | 1 | Asynchronous event level |
| wr_en_i | input | 1 | Stage a host write |
| wr_sel_i | input | 1 | 0 = count, 1 = threshold |
| wr_data_i | input | 32 | Write data |
| xact_end_i | input | 1 | Transaction-end strobe, commits the staged write |
| rd_sel_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data |
| alarm_o | output | 1 | Alarm flag |

## Verification
The shadow copy can be loaded by the falling-edge save and by a host count commit in the same clock. The bench stages a count write while the event is high. It then drops event_i and fires xact_end_i exactly two clocks later, which is the clock in which the synchronised falling edge is seen. It judges the outcome by reading both the count and the shadow copy. Both must hold the written value and not the old count.

// File: rtl/etc_pkg.sv
package etc_pkg;
  typedef enum logic [1:0] {
    RD_COUNT  = 2'd0,
    RD_SHADOW = 2'd1,
    RD_THRESH = 2'd2,
    RD_FLAGS  = 2'd3
  } rd_sel_e;

  typedef enum logic {
    WR_COUNT  = 1'b0,
    WR_THRESH = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= async_i;
        else             chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/etc_host_port.sv
module etc_host_port
  import etc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_lvl_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         xact_end_i,
  output logic         cnt_wr_o,
  output logic         thr_wr_o,
  output logic [W-1:0] data_o
);
  logic         stg_vld_q;
  wr_sel_e      stg_sel_q;
  logic [W-1:0] stg_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_vld_q  <= 1'b0;
      stg_sel_q  <= WR_COUNT;
      stg_data_q <= '0;
    end else if (wr_en_i) begin
      stg_vld_q  <= 1'b1;
      stg_sel_q  <= wr_sel_e'(wr_sel_i);
      stg_data_q <= wr_data_i;
    end else if (xact_end_i) begin
      stg_vld_q  <= 1'b0;
    end
  end

  // count writes are gated by the event level at commit time
  assign cnt_wr_o = xact_end_i & stg_vld_q & (stg_sel_q == WR_COUNT) & ~evt_lvl_i;
  assign thr_wr_o = xact_end_i & stg_vld_q & (stg_sel_q == WR_THRESH);
  assign data_o   = stg_data_q;
endmodule

// File: rtl/etc_accum.sv
module etc_accum #(
  parameter int          W            = 32,
  parameter logic [W-1:0] PERSIST_INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         snap_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] shadow_o,
  output logic         restore_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, shadow_q;
  logic         restore_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) restore_q <= 1'b1;
    else         restore_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restore_q)              cnt_q <= shadow_q;
    else if (wr_i)                   cnt_q <= wr_data_i;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // host write outranks the falling-edge save
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= PERSIST_INIT;
    else if (wr_i)   shadow_q <= wr_data_i;
    else if (snap_i) shadow_q <= cnt_q;
  end

  assign cnt_o     = cnt_q;
  assign shadow_o  = shadow_q;
  assign restore_o = restore_q;
endmodule

// File: rtl/etc_alarm.sv
module etc_alarm #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         thr_wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] thr_o,
  output logic         alarm_o
);
  logic [W-1:0] thr_q;
  logic         alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_q <= '0;
    else if (thr_wr_i) thr_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else         alarm_q <= (thr_q != '0) && (cnt_i >= thr_q);
  end

  assign thr_o   = thr_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/elapsed_timer_top.sv
module elapsed_timer_top
  import etc_pkg::*;
#(
  parameter int           W            = 32,
  parameter int           SYNC_STAGES  = 2,
  parameter logic [W-1:0] PERSIST_INIT = 32'h0000_0040
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         event_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         xact_end_i,
  input  logic [1:0]   rd_sel_i,
  output logic [W-1:0] rd_data_o,
  output logic         alarm_o
);
  logic         evt_lvl, evt_fall, cnt_wr, thr_wr, restore;
  logic [W-1:0] wdata, cnt, shadow, thr;

  etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(event_i), .level_o(evt_lvl), .fall_o(evt_fall)
  );

  etc_host_port #(.W(W)) u_host (
    .clk_i, .rst_ni, .evt_lvl_i(evt_lvl), .wr_en_i, .wr_sel_i, .wr_data_i,
    .xact_end_i, .cnt_wr_o(cnt_wr), .thr_wr_o(thr_wr), .data_o(wdata)
  );

  etc_accum #(.W(W), .PERSIST_INIT(PERSIST_INIT)) u_accum (
    .clk_i, .rst_ni, .inc_i(evt_lvl & tick_i), .snap_i(evt_fall), .wr_i(cnt_wr),
    .wr_data_i(wdata), .cnt_o(cnt), .shadow_o(shadow), .restore_o(restore)
  );

  etc_alarm #(.W(W)) u_alarm (
    .clk_i, .rst_ni, .thr_wr_i(thr_wr), .wr_data_i(wdata), .cnt_i(cnt),
    .thr_o(thr), .alarm_o(alarm_o)
  );

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      RD_COUNT:  rd_data_o = cnt;
      RD_SHADOW: rd_data_o = shadow;
      RD_THRESH: rd_data_o = thr;
      default:   rd_data_o = {{(W-1){1'b0}}, alarm_o};
    endcase
  end
endmodule

// File: rtl/etc_checker.sv
module etc_checker #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         evt_lvl,
  input logic         evt_fall,
  input logic         cnt_wr,
  input logic         restore,
  input logic [W-1:0] cnt,
  input logic [W-1:0] shadow,
  input logic [W-1:0] thr,
  input logic         alarm_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_lvl && tick_i && !cnt_wr && !restore && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

  // R3
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_MAX && !cnt_wr && !restore) |=> cnt == CNT_MAX);

  // R4
  shadow_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_fall && !cnt_wr) |=> shadow == $past(cnt));

  // R7
  alarm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr != '0 && cnt >= thr) |=> alarm_o);

  // R8
  zero_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr == '0) |=> !alarm_o);

  // R9
  alarm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr != '0 && cnt < thr) |=> !alarm_o);

  // R5
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |-> !evt_lvl);
endmodule

bind elapsed_timer_top etc_checker #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .evt_lvl(evt_lvl),
  .evt_fall(evt_fall), .cnt_wr(cnt_wr), .restore(restore), .cnt(cnt),
  .shadow(shadow), .thr(thr), .alarm_o(alarm_o)
);

// File: tb/elapsed_timer_top_tb.sv
module elapsed_timer_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, event_i = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0, xact_end_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_sel_i = 2'd0;
  logic [31:0] rd_data_o;
  logic        alarm_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct {string req; logic [1:0] sel; logic [31:0] exp;} item_t;
  item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  elapsed_timer_top u_dut (
    .clk_i, .rst_ni, .tick_i, .event_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .xact_end_i, .rd_sel_i, .rd_data_o, .alarm_o
  );

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(negedge clk_i);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        rd_sel_i = it.sel;
        #1;
        n_tests++;
        if (rd_data_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, rd_data_o, it.exp);
        end
        if (it.sel == 2'd3 && alarm_o !== it.exp[0]) begin
          n_fail++;
          $display("FAIL %s alarm_o actual=%b expected=%b", it.req, alarm_o, it.exp[0]);
        end
      end
    end
  end

  task automatic expect_rd(string req, logic [1:0] sel, logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic settle();
    wait (sb_q.size() == 0);
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk_i);
      tick_i = 1'b0; @(negedge clk_i);
    end
  endtask

  task automatic host_wr(logic sel, logic [31:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0; xact_end_i = 1'b1;
    @(negedge clk_i);
    xact_end_i = 1'b0;
    idle(3);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(3);
    // R1 reset state
    expect_rd("R1", 2'd0, 32'h40);
    expect_rd("R1", 2'd1, 32'h40);
    expect_rd("R1", 2'd2, 32'h0);
    expect_rd("R11", 2'd3, 32'h0);
    settle();

    // R2 ticks ignored with event low
    ticks(5);
    expect_rd("R2", 2'd0, 32'h40);
    settle();

    // R2 counting while high
    event_i = 1'b1; idle(4);
    ticks(5);
    expect_rd("R2", 2'd0, 32'h45);
    expect_rd("R4", 2'd1, 32'h40);
    settle();

    // R4 falling edge saves count
    event_i = 1'b0; idle(5);
    expect_rd("R4", 2'd1, 32'h45);
    expect_rd("R4", 2'd0, 32'h45);
    settle();

    // R6 threshold write, below threshold
    host_wr(1'b1, 32'h50);
    expect_rd("R6", 2'd2, 32'h50);
    expect_rd("R7", 2'd3, 32'h0);
    settle();

    // R7 equal then above
    event_i = 1'b1; idle(4);
    ticks(11); idle(2);
    expect_rd("R7", 2'd0, 32'h50);
    expect_rd("R7", 2'd3, 32'h1);
    settle();
    ticks(16); idle(2);
    expect_rd("R7", 2'd0, 32'h60);
    expect_rd("R7", 2'd3, 32'h1);
    settle();

    // R5 count write ignored while event high
    host_wr(1'b0, 32'h0);
    expect_rd("R5", 2'd0, 32'h60);
    expect_rd("R5", 2'd1, 32'h45);
    settle();

    // R6 threshold write accepted while high; R9 clears on raise
    host_wr(1'b1, 32'h70);
    expect_rd("R6", 2'd2, 32'h70);
    expect_rd("R9", 2'd3, 32'h0);
    settle();
    host_wr(1'b1, 32'h50);
    expect_rd("R7", 2'd3, 32'h1);
    settle();

    // R5 write zero with event low; R9 clears
    event_i = 1'b0; idle(5);
    expect_rd("R4", 2'd1, 32'h60);
    settle();
    host_wr(1'b0, 32'h0);
    expect_rd("R5", 2'd0, 32'h0);
    expect_rd("R5", 2'd1, 32'h0);
    expect_rd("R9", 2'd3, 32'h0);
    settle();

    // R8 zero threshold disables
    host_wr(1'b0, 32'h80);
    expect_rd("R7", 2'd3, 32'h1);
    settle();
    host_wr(1'b1, 32'h0);
    expect_rd("R8", 2'd3, 32'h0);
    expect_rd("R8", 2'd0, 32'h80);
    settle();

    // R3 saturation
    host_wr(1'b0, 32'hFFFF_FFFE);
    event_i = 1'b1; idle(4);
    ticks(3);
    expect_rd("R3", 2'd0, 32'hFFFF_FFFF);
    expect_rd("R8", 2'd3, 32'h0);
    settle();

    // R10 commit and falling edge in the same clock
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'h1234;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    event_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    xact_end_i = 1'b1;
    @(negedge clk_i);
    xact_end_i = 1'b0;
    idle(3);
    expect_rd("R10", 2'd0, 32'h1234);
    expect_rd("R10", 2'd1, 32'h1234);
    settle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule